// File: doc/BRIEF.md
# PWM stuck-duty fault detector

This block watches a set of logic-level PWM channels and raises a per-channel fault flag when a channel appears to have stopped crossing zero and settled near a DC level. A period-start strobe marks the beginning of each PWM period. A tick enable paces the measurement so that one full period is 128 ticks. For every channel, the block counts the ticks during which the PWM bit is high, which gives the duty of the period that has just ended. It judges that duty against a threshold derived from a shared 6-bit code.

The mode input selects how the threshold code is read. Ternary mode uses a single upper limit: a duty at or above the limit counts as a violation. Binary mode uses a window that is symmetric about half the period: a duty outside the window counts as a violation. Each channel keeps its own count of consecutive violating periods. When that count exceeds a shared 8-bit persistence limit, the channel's fault flag is latched. The flag stays set until it is cleared per channel. It only watches the logic-level modulator outputs and never the amplified bridge outputs.

Each channel runs a four-state machine. SYNC waits for the first strobe after reset. CLEAN means the last judged period was not violating. SUSPECT means violations are being counted but the limit has not yet been passed. TRIPPED means the fault is latched. The transitions are:
- SYNC to CLEAN on the first strobe.
- CLEAN or SUSPECT to TRIPPED when a violation pushes the run count past the limit.
- CLEAN or SUSPECT to SUSPECT on any other violation.
- CLEAN or SUSPECT to CLEAN on a period without a violation.
- TRIPPED to CLEAN or SUSPECT on a clear that does not coincide with a fresh trip. It goes to SUSPECT if the run count is still non-zero.

Top module: `pwm_dc_guard`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every bit of `fault` is 0.
- R2: A channel's duty is the number of cycles with `tick_en`=1 and its PWM bit high, counted from a strobe cycle (inclusive) up to the next strobe cycle (exclusive), saturating at 128. The first strobe after reset only starts a measurement, and anything seen before it is never judged.
- R3: With `mode_bin`=0 (ternary), a period violates when duty >= 2*`thr_code`+1.
- R4: With `mode_bin`=1 (binary), a period violates when duty > 64+`thr_code` or duty < 64-`thr_code`. A duty equal to either limit does not violate.
- R5: The same duty and code can violate in one mode and not in the other. `mode_bin` alone selects between R3 and R4.
- R6: A channel's `fault` bit sets in the cycle after a strobe once its run of consecutive violating periods exceeds `hold_lim`. With `hold_lim`=0, the first violating period sets it, and with `hold_lim`=255 it takes the 256th. `fault` never rises except in the cycle after a strobe.
- R7: A non-violating period resets the channel's run count to zero.
- R8: The run count saturates and does not wrap. After more than 512 consecutive violations, a cleared flag is set again by the next violating period.
- R9: `fault` bits are sticky. A `flag_clr` bit asserted in a non-strobe cycle drops that channel's bit in the next cycle. A clear aimed at a channel that is not faulted has no effect.
- R10: If a clear and a new trip of the same channel fall in the same strobe cycle, the fault stays set.
- R11: Channels are independent. Each has its own measurement, run count and flag, and a clear of one channel leaves the others unchanged. The mode, code and limit are shared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | NCH | Logic-level PWM bit of each channel |
| period_start | input | 1 | One-cycle strobe at the start of each PWM period |
| tick_en | input | 1 | Measurement tick enable |
| mode_bin | input | 1 | 0 selects ternary, 1 selects binary threshold |
| thr_code | input | THR_W | Shared threshold code |
| hold_lim | input | LIM_W | Shared persistence limit in periods |
| flag_clr | input | NCH | Per-channel fault clear |
| fault | output | NCH | Sticky per-channel fault flags |

## Verification
A per-channel clear and a fresh trip of the same channel can fall in the same cycle, because both are decided in the strobe cycle that closes a period. The bench provokes this with both channels already tripped and the limit at zero. It asserts the clear for both channels in the strobe cycle, while one channel's closing period still violates and the other's is clean. In the cycle after the strobe, the violating channel must keep its flag and the clean one must drop it. A second pass with both periods violating must leave both flags set.

// File: rtl/pwm_dc_guard_pkg.sv
package pwm_dc_guard_pkg;

    typedef enum logic [1:0] {
        CH_SYNC    = 2'd0,
        CH_CLEAN   = 2'd1,
        CH_SUSPECT = 2'd2,
        CH_TRIPPED = 2'd3
    } chan_state_e;

endpackage

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter #(
    parameter int TICKS = 128,
    parameter int CNT_W = $clog2(TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm,
    input  logic             tick_en,
    input  logic             period_start,
    output logic [CNT_W-1:0] duty
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic             high_tick;

    assign high_tick = pwm & tick_en;

    // The strobe cycle opens a new period; its own tick belongs to that period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_start) begin
            cnt_q <= {{(CNT_W-1){1'b0}}, high_tick};
        end else if (high_tick && (cnt_q != FULL)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign duty = cnt_q;

endmodule

// File: rtl/pwm_dc_judge.sv
module pwm_dc_judge #(
    parameter int TICKS = 128,
    parameter int CNT_W = $clog2(TICKS + 1),
    parameter int THR_W = 6
) (
    input  logic             mode_bin,
    input  logic [THR_W-1:0] code,
    input  logic [CNT_W-1:0] duty,
    output logic             viol
);

    localparam int BASE_W = (CNT_W > THR_W + 1) ? CNT_W : THR_W + 1;
    localparam int W      = BASE_W + 1;
    localparam logic [W-1:0] HALF = W'(TICKS / 2);

    logic [W-1:0] d_x;
    logic [W-1:0] c_x;
    logic [W-1:0] tern_lim;
    logic [W-1:0] win_hi;
    logic [W-1:0] win_lo;
    logic         tern_viol;
    logic         bin_viol;

    always_comb begin
        d_x      = W'(duty);
        c_x      = W'(code);
        tern_lim = (c_x << 1) | W'(1);
        win_hi   = HALF + c_x;
        win_lo   = (c_x >= HALF) ? '0 : (HALF - c_x);
        tern_viol = (d_x >= tern_lim);
        bin_viol  = (d_x > win_hi) || (d_x < win_lo);
        viol      = mode_bin ? bin_viol : tern_viol;
    end

endmodule

// File: rtl/pwm_dc_chan_fsm.sv
module pwm_dc_chan_fsm
    import pwm_dc_guard_pkg::*;
#(
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             viol,
    input  logic [LIM_W-1:0] limit,
    input  logic             clr,
    output logic             tripped
);

    localparam int RUN_W = LIM_W + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

    chan_state_e      state_q;
    chan_state_e      state_d;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_d;
    logic             judged;
    logic             trip_now;

    assign judged = strobe && (state_q != CH_SYNC);

    always_comb begin
        run_d = run_q;
        if (judged) begin
            if (!viol) begin
                run_d = '0;
            end else if (run_q != RUN_MAX) begin
                run_d = run_q + 1'b1;
            end
        end
        trip_now = judged && viol && (run_d > RUN_W'(limit));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_SYNC: begin
                if (strobe) begin
                    state_d = CH_CLEAN;
                end
            end
            CH_CLEAN, CH_SUSPECT: begin
                if (trip_now) begin
                    state_d = CH_TRIPPED;
                end else if (judged) begin
                    state_d = viol ? CH_SUSPECT : CH_CLEAN;
                end
            end
            CH_TRIPPED: begin
                if (!trip_now && clr) begin
                    state_d = (run_d != '0) ? CH_SUSPECT : CH_CLEAN;
                end
            end
            default: state_d = CH_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_SYNC;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        tripped = (state_q == CH_TRIPPED);
    end

endmodule

// File: rtl/pwm_dc_guard.sv
module pwm_dc_guard #(
    parameter int NCH   = 2,
    parameter int TICKS = 128,
    parameter int THR_W = 6,
    parameter int LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   pwm_in,
    input  logic             period_start,
    input  logic             tick_en,
    input  logic             mode_bin,
    input  logic [THR_W-1:0] thr_code,
    input  logic [LIM_W-1:0] hold_lim,
    input  logic [NCH-1:0]   flag_clr,
    output logic [NCH-1:0]   fault
);

    localparam int CNT_W = $clog2(TICKS + 1);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [CNT_W-1:0] duty;
        logic             viol;

        pwm_duty_meter #(
            .TICKS (TICKS),
            .CNT_W (CNT_W)
        ) u_meter (
            .clk          (clk),
            .rst_n        (rst_n),
            .pwm          (pwm_in[ch]),
            .tick_en      (tick_en),
            .period_start (period_start),
            .duty         (duty)
        );

        pwm_dc_judge #(
            .TICKS (TICKS),
            .CNT_W (CNT_W),
            .THR_W (THR_W)
        ) u_judge (
            .mode_bin (mode_bin),
            .code     (thr_code),
            .duty     (duty),
            .viol     (viol)
        );

        pwm_dc_chan_fsm #(
            .LIM_W (LIM_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .strobe  (period_start),
            .viol    (viol),
            .limit   (hold_lim),
            .clr     (flag_clr[ch]),
            .tripped (fault[ch])
        );
    end

endmodule

// File: rtl/pwm_dc_guard_chk.sv
module pwm_dc_guard_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           period_start,
    input logic [NCH-1:0] flag_clr,
    input logic [NCH-1:0] fault
);

    // R1: flags are quiet in the first cycle out of reset
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fault == '0));

    // R6: a flag only rises in the cycle after a strobe
    a_r6_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault & ~$past(fault))) |-> $past(period_start));

    // R9: a set flag that was not cleared stays set
    a_r9_hold_unless_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fault) & ~$past(flag_clr) & ~fault) == '0));

    // R9: a clear outside a strobe cycle always drops the flag
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(period_start) |-> (($past(flag_clr) & fault) == '0));

endmodule

bind pwm_dc_guard pwm_dc_guard_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .flag_clr     (flag_clr),
    .fault        (fault)
);

// File: tb/sim_pwm_dc_guard.sv
module sim_pwm_dc_guard;

    typedef struct packed {
        logic       mode;
        logic [5:0] code;
        logic [7:0] lim;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [3:0] nper;
        logic [1:0] exp;
    } vec_t;

    // exp bit 0 is channel 0, bit 1 is channel 1
    localparam int NVEC = 10;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 6'd10, 8'd2, 8'd21,  8'd20,  4'd3, 2'b01},  // R3 at/below threshold, R6
        '{1'b0, 6'd10, 8'd3, 8'd21,  8'd128, 4'd3, 2'b00},  // R6 run equal to limit
        '{1'b0, 6'd0,  8'd0, 8'd1,   8'd0,   4'd1, 2'b01},  // R3 lowest code, R6 limit 0
        '{1'b0, 6'd63, 8'd1, 8'd127, 8'd126, 4'd2, 2'b01},  // R3 highest code
        '{1'b1, 6'd8,  8'd1, 8'd72,  8'd73,  4'd2, 2'b10},  // R4 upper edge
        '{1'b1, 6'd8,  8'd1, 8'd56,  8'd55,  4'd2, 2'b10},  // R4 lower edge
        '{1'b1, 6'd0,  8'd0, 8'd64,  8'd63,  4'd1, 2'b10},  // R4 zero-width window
        '{1'b1, 6'd63, 8'd0, 8'd0,   8'd128, 4'd1, 2'b11},  // R4 widest window
        '{1'b1, 6'd20, 8'd4, 8'd10,  8'd64,  4'd5, 2'b01},  // R5 binary reading
        '{1'b0, 6'd20, 8'd0, 8'd64,  8'd10,  4'd1, 2'b01}   // R5 ternary reading
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwm_in = '0;
    logic       period_start = 1'b0;
    logic       tick_en = 1'b0;
    logic       mode_bin = 1'b0;
    logic [5:0] thr_code = '0;
    logic [7:0] hold_lim = '0;
    logic [1:0] flag_clr = '0;
    logic [1:0] fault;
    logic [1:0] f_obs = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwm_dc_guard #(.NCH(2), .TICKS(128), .THR_W(6), .LIM_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
        .tick_en(tick_en), .mode_bin(mode_bin), .thr_code(thr_code),
        .hold_lim(hold_lim), .flag_clr(flag_clr), .fault(fault)
    );

    task automatic check(input string req, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: fault=%b expected %b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; period_start = 1'b0; flag_clr = '0; pwm_in = '0; tick_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One 128-cycle period opened by a strobe; f_obs holds fault just after the strobe.
    task automatic run_period(input int d0, input int d1, input int ten, input logic [1:0] clr0);
        for (int c = 0; c < 128; c++) begin
            @(negedge clk);
            if (c == 1) f_obs = fault;
            period_start = (c == 0);
            pwm_in[0]    = (c < d0);
            pwm_in[1]    = (c < d1);
            tick_en      = (c < ten);
            flag_clr     = (c == 0) ? clr0 : 2'b00;
        end
    endtask

    task automatic strobe_only();
        @(negedge clk);
        period_start = 1'b1; pwm_in = '0; tick_en = 1'b1; flag_clr = '0;
        @(negedge clk);
        period_start = 1'b0;
        f_obs = fault;
    endtask

    task automatic pulse_clear(input logic [1:0] mask);
        @(negedge clk);
        period_start = 1'b0; flag_clr = mask;
        @(negedge clk);
        flag_clr = '0;
        f_obs = fault;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1 in reset", fault, 2'b00);
        do_reset();
        @(negedge clk);
        check("R1 after release", fault, 2'b00);

        // Table walk: R3 R4 R5 R6
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            mode_bin = TBL[v].mode;
            thr_code = TBL[v].code;
            hold_lim = TBL[v].lim;
            for (int k = 0; k < int'(TBL[v].nper); k++)
                run_period(int'(TBL[v].d0), int'(TBL[v].d1), 128, 2'b00);
            strobe_only();
            check($sformatf("R3/R4/R5/R6 vector %0d", v), f_obs, TBL[v].exp);
        end

        // R2: activity before the first strobe is never judged
        do_reset();
        mode_bin = 1'b0; thr_code = 6'd0; hold_lim = 8'd0;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            pwm_in = 2'b11; tick_en = 1'b1; period_start = 1'b0;
        end
        strobe_only();
        check("R2 first strobe only syncs", f_obs, 2'b00);

        // R2: only enabled ticks count (threshold 41)
        do_reset();
        mode_bin = 1'b0; thr_code = 6'd20; hold_lim = 8'd0;
        run_period(0, 0, 128, 2'b00);
        run_period(128, 128, 40, 2'b00);
        run_period(128, 128, 41, 2'b00);
        check("R2 40 enabled ticks", f_obs, 2'b00);
        strobe_only();
        check("R2 41 enabled ticks", f_obs, 2'b11);

        // R7 with R11: clean period restarts ch0's run, ch1 runs on
        do_reset();
        mode_bin = 1'b0; thr_code = 6'd10; hold_lim = 8'd2;
        run_period(30, 30, 128, 2'b00);
        run_period(30, 30, 128, 2'b00);
        run_period(0, 30, 128, 2'b00);
        run_period(30, 30, 128, 2'b00);
        run_period(30, 30, 128, 2'b00);
        check("R7 R11 after reset of run", f_obs, 2'b10);
        run_period(30, 30, 128, 2'b00);
        check("R7 two after clean", f_obs, 2'b10);
        strobe_only();
        check("R7 third after clean", f_obs, 2'b11);

        // R9: sticky over clean periods, per-channel clear
        run_period(0, 0, 128, 2'b00);
        run_period(0, 0, 128, 2'b00);
        check("R9 sticky", f_obs, 2'b11);
        pulse_clear(2'b01);
        check("R9 R11 clear ch0", f_obs, 2'b10);
        pulse_clear(2'b01);
        check("R9 clear on idle channel", f_obs, 2'b10);

        // R10: clear in the strobe cycle that trips again
        do_reset();
        mode_bin = 1'b0; thr_code = 6'd10; hold_lim = 8'd0;
        run_period(30, 30, 128, 2'b00);
        run_period(30, 30, 128, 2'b00);
        check("R10 setup", f_obs, 2'b11);
        run_period(30, 0, 128, 2'b11);
        check("R10 both trip again", f_obs, 2'b11);
        run_period(0, 0, 128, 2'b11);
        check("R10 ch0 wins, ch1 clears", f_obs, 2'b01);

        // R6 limit 255 and R8 saturation
        do_reset();
        mode_bin = 1'b0; thr_code = 6'd0; hold_lim = 8'd255;
        for (int k = 1; k <= 517; k++) begin
            if (k == 517) begin
                pulse_clear(2'b01);
                check("R8 clear after long run", f_obs, 2'b00);
            end
            run_period(128, 0, 128, 2'b00);
            if (k == 256) check("R6 255 violations", f_obs, 2'b00);
            if (k == 257) check("R6 256 violations", f_obs, 2'b01);
            if (k == 517) check("R8 saturated run re-trips", f_obs, 2'b01);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule